// File: doc/BRIEF.md
# Halt-Gated Floppy Bus Interface

This block sits between the I/O side of an 8-bit Z80-style processor bus and a floppy disk controller with a four-register interface. It turns the port address of each I/O cycle into chip selects. One select picks the controller and names the register to use. A second select covers a 16-port window for a hard disk adapter. The block also holds one read/write control byte of its own, which drives the drive-select and option lines.

Its central feature is how it wakes the processor. The block does not make software poll the controller status. It pulls the non-maskable interrupt low only while the processor is stopped in HALT and the controller is raising a data request or a completion interrupt. Software therefore runs a loop of HALT instructions. Each interrupt moves one byte through an input-and-increment handler at the fixed NMI entry address, 0066h. Because the interrupt input is edge-sensitive, the request is dropped as soon as the processor leaves HALT, so every byte of a 128-byte sector produces a fresh falling edge.

The control byte reads back its low seven bits exactly. Boot code uses this to detect the adapter: it writes 1Eh, reads the port back, masks the result with 7Fh and compares it with 1Eh. Bit 7 of that read is the live controller interrupt level.

Top module: `fdc_disk_glue`

## Requirements
- R1: While rst_n is low, and after it is released, ctrl_o holds 00h and nmi_n stays high until an interrupt condition arises.
- R2: An I/O cycle to ports 44h through 47h drives fdc_cs_n low, with fdc_reg equal to address bits 1:0 (00 command/status, 01 track, 10 sector, 11 data). At most one of the FDC select, the control-port access and the hard disk select is active at a time.
- R3: A port is selected only when iorq_n is low and m1_n is high. An interrupt-acknowledge cycle (m1_n low) or an idle bus selects nothing and leaves ctrl_o unchanged.
- R4: A write cycle to port 48h loads data_i into ctrl_o at the next rising clock edge. Without such a write, ctrl_o keeps its value.
- R5: A read cycle to port 48h raises data_oe and returns data_o[6:0] = ctrl_o[6:0] and data_o[7] = fdc_intrq, so that writing 1Eh and masking the readback with 7Fh yields 1Eh. In any other cycle data_oe is low and data_o is 00h.
- R6: hdd_cs_n is low for an I/O cycle to any port from 50h to 5Fh, and high for 4Fh, 60h and every other port.
- R7: nmi_n goes low at the rising edge that follows a cycle in which halt_n is low and fdc_drq or fdc_intrq is high.
- R8: nmi_n returns high at the first rising edge after halt_n goes high, even if the request input is still high.
- R9: While halt_n is high, no level or pulse on fdc_drq or fdc_intrq drives nmi_n low.
- R10: A transfer of 128 bytes, made of HALT, request, acknowledge and read for each byte, produces exactly 128 falling edges on nmi_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-synchronous clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 8 | Low byte of the I/O port address |
| iorq_n | input | 1 | I/O request strobe, active low |
| m1_n | input | 1 | Opcode-fetch / acknowledge indicator, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| data_i | input | 8 | Data bus from the processor |
| data_o | output | 8 | Read data for the control port |
| data_oe | output | 1 | High while data_o must drive the bus |
| halt_n | input | 1 | Processor HALT status, active low |
| fdc_drq | input | 1 | Controller data request |
| fdc_intrq | input | 1 | Controller completion interrupt |
| fdc_cs_n | output | 1 | Controller chip select, active low |
| fdc_reg | output | 2 | Controller register index |
| hdd_cs_n | output | 1 | Hard disk window select, active low |
| ctrl_o | output | 8 | Latched control byte |
| nmi_n | output | 1 | Non-maskable interrupt request, active low |

## Verification
The address decoder and the halt-gated interrupt path are separate pieces of logic, but both change in the same clock when software touches the control port during the cycle in which the controller raises a request while the processor is halted. The random phase drives the bus lines, halt_n and both request lines independently every cycle. This makes control-port reads and writes land on interrupt assertion and release edges, and each side is judged against its own model in that same cycle. A control read taken while fdc_intrq changes state is also checked, because bit 7 must show the live level while bits 6:0 show the latch.

// File: rtl/fdc_glue_pkg.sv
package fdc_glue_pkg;

  localparam int PORT_W = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_FDC  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_HDD  = 2'd3
  } port_sel_e;

  // true when port a falls inside the aligned window of 2**span_log2 ports at base
  function automatic logic in_window(input logic [PORT_W-1:0] a,
                                     input logic [PORT_W-1:0] base,
                                     input int unsigned       span_log2);
    logic [PORT_W-1:0] keep;
    keep = {PORT_W{1'b1}} << span_log2;
    return (a & keep) == (base & keep);
  endfunction

  // a cycle may select a port only as a plain I/O access, never an acknowledge
  function automatic logic plain_io(input logic iorq_n, input logic m1_n);
    return !iorq_n && m1_n;
  endfunction

  // readback word: live status in the top bit, latched bits below
  function automatic logic [PORT_W-1:0] readback_word(input logic [PORT_W-1:0] q,
                                                      input logic              live);
    return {live, q[PORT_W-2:0]};
  endfunction

  // wake condition: processor halted and controller wants service
  function automatic logic wake_cond(input logic halt_n, input logic drq, input logic intrq);
    return !halt_n && (drq || intrq);
  endfunction

endpackage

// File: rtl/fdc_port_decode.sv
module fdc_port_decode
  import fdc_glue_pkg::*;
#(
  parameter logic [PORT_W-1:0] FDC_BASE      = 8'h44,
  parameter int unsigned       FDC_SPAN_LOG2 = 2,
  parameter logic [PORT_W-1:0] CTRL_PORT     = 8'h48,
  parameter logic [PORT_W-1:0] HDD_BASE      = 8'h50,
  parameter int unsigned       HDD_SPAN_LOG2 = 4
) (
  input  logic [PORT_W-1:0]        addr_i,
  input  logic                     iorq_n,
  input  logic                     m1_n,
  output port_sel_e                sel_o,
  output logic [FDC_SPAN_LOG2-1:0] reg_idx_o
);

  logic io_ok;
  logic hit_fdc;
  logic hit_ctrl;
  logic hit_hdd;

  assign io_ok    = plain_io(iorq_n, m1_n);
  assign hit_fdc  = in_window(addr_i, FDC_BASE, FDC_SPAN_LOG2);
  assign hit_ctrl = in_window(addr_i, CTRL_PORT, 0);
  assign hit_hdd  = in_window(addr_i, HDD_BASE, HDD_SPAN_LOG2);

  always_comb begin
    sel_o = SEL_NONE;
    if (io_ok) begin
      if (hit_fdc)       sel_o = SEL_FDC;
      else if (hit_ctrl) sel_o = SEL_CTRL;
      else if (hit_hdd)  sel_o = SEL_HDD;
    end
  end

  assign reg_idx_o = addr_i[FDC_SPAN_LOG2-1:0];

endmodule

// File: rtl/fdc_ctrl_latch.sv
module fdc_ctrl_latch #(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] RST_VAL  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= RST_VAL;
    else if (load_i) q_o <= d_i;
  end

endmodule

// File: rtl/fdc_halt_nmi.sv
module fdc_halt_nmi
  import fdc_glue_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic halt_n,
  input  logic drq,
  input  logic intrq,
  output logic wake_o,
  output logic nmi_n
);

  logic nmi_q;

  assign wake_o = wake_cond(halt_n, drq, intrq);

  // registered so the pin is glitch free; leaving HALT clears it next edge
  always_ff @(posedge clk) begin
    if (!rst_n) nmi_q <= 1'b0;
    else        nmi_q <= wake_o;
  end

  assign nmi_n = !nmi_q;

endmodule

// File: rtl/fdc_disk_glue.sv
module fdc_disk_glue
  import fdc_glue_pkg::*;
#(
  parameter logic [PORT_W-1:0] FDC_BASE      = 8'h44,
  parameter int unsigned       FDC_SPAN_LOG2 = 2,
  parameter logic [PORT_W-1:0] CTRL_PORT     = 8'h48,
  parameter logic [PORT_W-1:0] HDD_BASE      = 8'h50,
  parameter int unsigned       HDD_SPAN_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] addr_i,
  input  logic              iorq_n,
  input  logic              m1_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [PORT_W-1:0] data_i,
  output logic [PORT_W-1:0] data_o,
  output logic              data_oe,
  input  logic              halt_n,
  input  logic              fdc_drq,
  input  logic              fdc_intrq,
  output logic              fdc_cs_n,
  output logic [1:0]        fdc_reg,
  output logic              hdd_cs_n,
  output logic [PORT_W-1:0] ctrl_o,
  output logic              nmi_n
);

  localparam int REG_W = FDC_SPAN_LOG2;

  port_sel_e         sel;
  logic [REG_W-1:0]  reg_idx;
  logic              ctrl_wr;
  logic              ctrl_rd;
  logic              wake_req;

  fdc_port_decode #(
    .FDC_BASE      (FDC_BASE),
    .FDC_SPAN_LOG2 (FDC_SPAN_LOG2),
    .CTRL_PORT     (CTRL_PORT),
    .HDD_BASE      (HDD_BASE),
    .HDD_SPAN_LOG2 (HDD_SPAN_LOG2)
  ) u_dec (
    .addr_i    (addr_i),
    .iorq_n    (iorq_n),
    .m1_n      (m1_n),
    .sel_o     (sel),
    .reg_idx_o (reg_idx)
  );

  assign ctrl_wr = (sel == SEL_CTRL) && !wr_n;
  assign ctrl_rd = (sel == SEL_CTRL) && !rd_n;

  fdc_ctrl_latch #(
    .WIDTH   (PORT_W),
    .RST_VAL ('0)
  ) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (ctrl_wr),
    .d_i    (data_i),
    .q_o    (ctrl_o)
  );

  fdc_halt_nmi u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .halt_n (halt_n),
    .drq    (fdc_drq),
    .intrq  (fdc_intrq),
    .wake_o (wake_req),
    .nmi_n  (nmi_n)
  );

  assign fdc_cs_n = (sel != SEL_FDC);
  assign hdd_cs_n = (sel != SEL_HDD);
  assign fdc_reg  = 2'(reg_idx);
  assign data_oe  = ctrl_rd;
  assign data_o   = ctrl_rd ? readback_word(ctrl_o, fdc_intrq) : '0;

endmodule

// File: rtl/fdc_glue_checker.sv
module fdc_glue_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       iorq_n,
  input logic       m1_n,
  input logic [7:0] data_i,
  input logic [7:0] data_o,
  input logic       data_oe,
  input logic       halt_n,
  input logic       fdc_drq,
  input logic       fdc_intrq,
  input logic       fdc_cs_n,
  input logic       hdd_cs_n,
  input logic [7:0] ctrl_o,
  input logic       nmi_n,
  input logic       ctrl_wr,
  input logic       ctrl_rd,
  input logic       wake_req
);

  assert_nmi_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_n && (fdc_drq || fdc_intrq)) |=> !nmi_n);

  assert_nmi_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_n |-> $past(!halt_n && (fdc_drq || fdc_intrq)));

  assert_nmi_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_n |=> nmi_n);

  assert_wake_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> !halt_n);

  assert_qualify_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fdc_cs_n || !hdd_cs_n || ctrl_wr || ctrl_rd) |-> (!iorq_n && m1_n));

  assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!fdc_cs_n, !hdd_cs_n, ctrl_wr || ctrl_rd}));

  assert_latch_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_o == $past(data_i)));

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_o));

  assert_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd |-> (data_oe && data_o[6:0] == ctrl_o[6:0] && data_o[7] == fdc_intrq));

  assert_quiet_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_o == 8'h00));

endmodule

bind fdc_disk_glue fdc_glue_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iorq_n    (iorq_n),
  .m1_n      (m1_n),
  .data_i    (data_i),
  .data_o    (data_o),
  .data_oe   (data_oe),
  .halt_n    (halt_n),
  .fdc_drq   (fdc_drq),
  .fdc_intrq (fdc_intrq),
  .fdc_cs_n  (fdc_cs_n),
  .hdd_cs_n  (hdd_cs_n),
  .ctrl_o    (ctrl_o),
  .nmi_n     (nmi_n),
  .ctrl_wr   (ctrl_wr),
  .ctrl_rd   (ctrl_rd),
  .wake_req  (wake_req)
);

// File: tb/sim_fdc_disk_glue.sv
module sim_fdc_disk_glue;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic       iorq_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] data_i = 8'h00;
  logic [7:0] data_o;
  logic       data_oe;
  logic       halt_n = 1'b1, fdc_drq = 1'b0, fdc_intrq = 1'b0;
  logic       fdc_cs_n, hdd_cs_n, nmi_n;
  logic [1:0] fdc_reg;
  logic [7:0] ctrl_o;

  int checks = 0;
  int errors = 0;
  int nmi_edges = 0;
  logic [7:0] m_ctrl = 8'h00;

  always #2 clk = ~clk;

  fdc_disk_glue u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .iorq_n(iorq_n), .m1_n(m1_n),
    .rd_n(rd_n), .wr_n(wr_n), .data_i(data_i), .data_o(data_o), .data_oe(data_oe),
    .halt_n(halt_n), .fdc_drq(fdc_drq), .fdc_intrq(fdc_intrq), .fdc_cs_n(fdc_cs_n),
    .fdc_reg(fdc_reg), .hdd_cs_n(hdd_cs_n), .ctrl_o(ctrl_o), .nmi_n(nmi_n)
  );

  always @(negedge nmi_n) if (rst_n) nmi_edges++;

  // bench models, written from the requirements
  function automatic bit m_io();
    return (iorq_n == 1'b0) && (m1_n == 1'b1);
  endfunction
  function automatic bit m_fdc_hit();
    return m_io() && (addr_i >= 8'h44) && (addr_i <= 8'h47);
  endfunction
  function automatic bit m_hdd_hit();
    return m_io() && (addr_i[7:4] == 4'h5);
  endfunction
  function automatic bit m_ctrl_rd();
    return m_io() && (addr_i == 8'h48) && !rd_n;
  endfunction
  function automatic bit m_ctrl_wr();
    return m_io() && (addr_i == 8'h48) && !wr_n;
  endfunction
  function automatic logic [7:0] m_rdata();
    return m_ctrl_rd() ? ((m_ctrl & 8'h7F) | (fdc_intrq ? 8'h80 : 8'h00)) : 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_idle();
    iorq_n = 1'b1; m1_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic check_comb(input string tag);
    check(fdc_cs_n == !m_fdc_hit(), {tag, " R2 fdc_cs_n"}, fdc_cs_n, !m_fdc_hit());
    if (m_fdc_hit()) check(fdc_reg == addr_i[1:0], {tag, " R2 fdc_reg"}, fdc_reg, addr_i[1:0]);
    check(hdd_cs_n == !m_hdd_hit(), {tag, " R6 hdd_cs_n"}, hdd_cs_n, !m_hdd_hit());
    check(data_oe == m_ctrl_rd(), {tag, " R5 data_oe"}, data_oe, m_ctrl_rd());
    check(data_o == m_rdata(), {tag, " R5 data_o"}, data_o, m_rdata());
  endtask

  // one write cycle to a port, latch model updated at the edge
  task automatic io_write(input logic [7:0] port, input logic [7:0] val);
    @(negedge clk);
    addr_i = port; data_i = val; iorq_n = 1'b0; m1_n = 1'b1; wr_n = 1'b0; rd_n = 1'b1;
    @(posedge clk);
    if (m_ctrl_wr()) m_ctrl = val;
    @(negedge clk);
    bus_idle();
  endtask

  initial begin : watchdog
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h1E7F_0066));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(ctrl_o == 8'h00, "R1 ctrl_o in reset", ctrl_o, 8'h00);
    check(nmi_n == 1'b1, "R1 nmi_n in reset", nmi_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(ctrl_o == 8'h00 && nmi_n, "R1 after release", {ctrl_o, 7'b0, nmi_n}, 16'h0001);

    // R2 register map
    for (int p = 8'h44; p <= 8'h47; p++) begin
      addr_i = 8'(p); iorq_n = 1'b0; m1_n = 1'b1; rd_n = 1'b0;
      #1;
      check(!fdc_cs_n && fdc_reg == 2'(p - 8'h44), "R2 directed map", {fdc_cs_n, fdc_reg}, 2'(p - 8'h44));
      bus_idle();
    end

    // R3 acknowledge cycle and idle bus select nothing
    addr_i = 8'h45; iorq_n = 1'b0; m1_n = 1'b0; #1;
    check(fdc_cs_n && hdd_cs_n && !data_oe, "R3 m1 ack no select", fdc_cs_n, 1);
    bus_idle(); addr_i = 8'h48; wr_n = 1'b0; data_i = 8'h5A; #1;
    check(fdc_cs_n, "R3 idle no select", fdc_cs_n, 1);
    @(posedge clk); @(negedge clk); bus_idle();
    check(ctrl_o == 8'h00, "R3 idle write ignored", ctrl_o, 8'h00);
    iorq_n = 1'b0; m1_n = 1'b0; addr_i = 8'h48; wr_n = 1'b0; data_i = 8'hA5;
    @(posedge clk); @(negedge clk); bus_idle();
    check(ctrl_o == 8'h00, "R3 ack write ignored", ctrl_o, 8'h00);

    // R4/R5 detection sequence
    fdc_intrq = 1'b1;
    io_write(8'h48, 8'h1E);
    check(ctrl_o == 8'h1E, "R4 latch loaded", ctrl_o, 8'h1E);
    addr_i = 8'h48; iorq_n = 1'b0; rd_n = 1'b0; #1;
    check(data_oe && (data_o & 8'h7F) == 8'h1E, "R5 detect readback", data_o, 8'h9E);
    check(data_o[7] == 1'b1, "R5 live bit7 high", data_o, 8'h9E);
    fdc_intrq = 1'b0; #1;
    check(data_o == 8'h1E, "R5 live bit7 low", data_o, 8'h1E);
    bus_idle();
    io_write(8'h48, 8'hFF);
    check(ctrl_o == 8'hFF, "R4 full byte", ctrl_o, 8'hFF);
    io_write(8'h49, 8'h00);
    check(ctrl_o == 8'hFF, "R4 neighbour port ignored", ctrl_o, 8'hFF);

    // R6 window edges
    for (int p = 8'h4F; p <= 8'h60; p++) begin
      addr_i = 8'(p); iorq_n = 1'b0; m1_n = 1'b1; rd_n = 1'b0; #1;
      check(hdd_cs_n == !(p >= 8'h50 && p <= 8'h5F), "R6 window", hdd_cs_n, !(p >= 8'h50 && p <= 8'h5F));
      bus_idle();
    end

    // R7 intrq while halted, R8 release
    @(negedge clk); halt_n = 1'b0; fdc_intrq = 1'b1;
    @(negedge clk);
    check(nmi_n == 1'b0, "R7 intrq wakes halted cpu", nmi_n, 0);
    halt_n = 1'b1;
    @(negedge clk);
    check(nmi_n == 1'b1, "R8 release on halt exit", nmi_n, 1);
    fdc_intrq = 1'b0;

    // R10 128-byte halted transfer, R7/R8 per byte
    nmi_edges = 0;
    for (int b = 0; b < 128; b++) begin
      @(negedge clk); halt_n = 1'b0;
      @(negedge clk); @(negedge clk);
      check(nmi_n == 1'b1, "R7 no nmi before drq", nmi_n, 1);
      fdc_drq = 1'b1;
      @(negedge clk);
      check(nmi_n == 1'b0, "R7 drq while halted", nmi_n, 0);
      halt_n = 1'b1;
      @(negedge clk);
      check(nmi_n == 1'b1, "R8 drop with drq still high", nmi_n, 1);
      addr_i = 8'h47; iorq_n = 1'b0; rd_n = 1'b0; #1;
      check(!fdc_cs_n && fdc_reg == 2'b11, "R2 data reg during transfer", fdc_reg, 2'b11);
      fdc_drq = 1'b0;
      @(negedge clk); bus_idle();
    end
    @(negedge clk);
    check(nmi_edges == 128, "R10 one edge per byte", nmi_edges, 128);

    // R9 requests while running
    nmi_edges = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); fdc_drq = 1'b1; fdc_intrq = k[0];
      @(negedge clk);
      check(nmi_n == 1'b1, "R9 running no nmi", nmi_n, 1);
      fdc_drq = 1'b0; fdc_intrq = 1'b0;
    end
    @(negedge clk);
    check(nmi_edges == 0, "R9 no edges when running", nmi_edges, 0);

    // random phase: bus, halt and requests all independent
    for (int i = 0; i < 3000; i++) begin
      logic exp_nmi_n;
      @(negedge clk);
      if ($urandom_range(0, 1)) addr_i = 8'($urandom_range(8'h40, 8'h61));
      else                      addr_i = 8'($urandom);
      iorq_n = ($urandom_range(0, 3) == 0);
      m1_n   = ($urandom_range(0, 5) != 0);
      case ($urandom_range(0, 2))
        0: begin rd_n = 1'b0; wr_n = 1'b1; end
        1: begin rd_n = 1'b1; wr_n = 1'b0; end
        default: begin rd_n = 1'b1; wr_n = 1'b1; end
      endcase
      data_i    = 8'($urandom);
      halt_n    = ($urandom_range(0, 1) == 1);
      fdc_drq   = ($urandom_range(0, 2) == 0);
      fdc_intrq = ($urandom_range(0, 4) == 0);
      #1;
      check_comb("random");
      exp_nmi_n = !(!halt_n && (fdc_drq || fdc_intrq));
      @(posedge clk);
      if (m_ctrl_wr()) m_ctrl = data_i;
      @(negedge clk);
      check(ctrl_o == m_ctrl, "R4 random latch", ctrl_o, m_ctrl);
      check(nmi_n == exp_nmi_n, "R7 random nmi", nmi_n, exp_nmi_n);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule